// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column addresses of one SDRAM read or write burst, one per clock. A start pulse captures a 9-bit start column with the burst settings of that moment: a 3-bit length code, an order bit (sequential or interleaved), a write-single-beat bit and a read/write flag. From the next cycle on, the block presents one column per cycle with a valid flag, and marks the final beat with a last flag.

Fixed-length bursts of 1, 2, 4 or 8 beats stay inside the block of columns aligned to the burst length. The upper column bits never change during such a burst. A full-page burst steps through the 256 columns of a page and wraps back to its start. It has no natural end and runs until a stop pulse arrives. A stop pulse ends a burst of any length. A new start is accepted in any cycle, including the final beat of the current burst, so bursts can follow each other with no gap.

Top module: `burst_col_gen`

## Requirements
- R1: While no burst is active, `valid` and `last` are 0 and `col` is 0. This is also the state after reset.
- R2: The cycle after `start` is sampled high, `valid` is 1 and `col` equals the sampled `start_col`.
- R3: With order bit 0, beat i of a burst of length L (L = 2^k) shows `col` = (start_col with its low k bits replaced by (start_col + i) mod L).
- R4: With order bit 1 and a fixed length L = 2^k, beat i shows `col` = (start_col with its low k bits replaced by (start_col XOR i) mod L).
- R5: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 beats. `last` is 1 on the final beat only, and `valid` falls in the cycle after it.
- R6: The unused length codes 3'b100, 3'b101 and 3'b110 give a single-beat burst.
- R7: Length code 3'b111 gives a full-page burst. Column bits 7:0 count up from the start and wrap from 255 to 0, and bit 8 holds its start value. The order bit is ignored. `last` stays 0, and the burst runs until a stop arrives.
- R8: When both `is_write` and `wr_single` are 1 at start, the burst has one beat whatever its length code. A read with `wr_single` at 1 uses the programmed length.
- R9: A `stop` sampled in a cycle where `valid` is 1 and `start` is 0 makes `valid` 0 in the next cycle. A `stop` while idle has no effect on the following bursts.
- R10: A `start` sampled while a burst is active, including on its last beat, begins the new burst in the next cycle with no idle cycle between the two.
- R11: `last` is never 1 while `valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a burst with the settings sampled at this edge |
| start_col | input | 9 | First column of the burst |
| len_code | input | 3 | Burst length code |
| burst_type | input | 1 | Order: 0 sequential, 1 interleaved |
| wr_single | input | 1 | Writes are forced to one beat when 1 |
| is_write | input | 1 | 1 for a write burst, 0 for a read burst |
| stop | input | 1 | Ends the active burst |
| col | output | 9 | Column of the current beat |
| valid | output | 1 | A beat is being presented |
| last | output | 1 | The current beat is the final one of a fixed-length burst |

## Verification
Beat 0 appears one cycle after the edge that samples `start`, and beat i appears i cycles later. The effect of a stop or of a final beat shows as a low `valid` one cycle after that edge. The bench drives inputs on falling edges. At each falling edge it compares the outputs against beat i of a model that it steps one beat per cycle. When a stop or a last beat is seen, it checks for an idle output at the very next falling edge. In the back-to-back case it instead checks that the next burst's first column appears at that edge.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    localparam int COL_W  = 9;
    localparam int PAGE_W = 8;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        LEN_ONE   = 3'b000,
        LEN_TWO   = 3'b001,
        LEN_FOUR  = 3'b010,
        LEN_EIGHT = 3'b011,
        LEN_PAGE  = 3'b111
    } len_code_e;

    typedef struct packed {
        logic              full;
        logic              ilv;
        logic [PAGE_W-1:0] mask;
    } burst_mode_t;

    typedef struct packed {
        logic              active;
        logic [COL_W-1:0]  base;
        logic [PAGE_W-1:0] beat;
        burst_mode_t       mode;
    } burst_state_t;

    function automatic logic [PAGE_W-1:0] fixed_mask(input logic [CODE_W-1:0] code);
        logic [PAGE_W-1:0] m;
        m = '0;
        case (code)
            LEN_TWO:   m = PAGE_W'(1);
            LEN_FOUR:  m = PAGE_W'(3);
            LEN_EIGHT: m = PAGE_W'(7);
            default:   m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bcg_mode_decode.sv
module bcg_mode_decode
    import bcg_pkg::*;
(
    input  logic [CODE_W-1:0] len_code,
    input  logic              burst_type,
    input  logic              wr_single,
    input  logic              is_write,
    output burst_mode_t       mode
);

    logic single_forced;
    logic page_sel;

    assign single_forced = is_write & wr_single;
    assign page_sel      = (len_code == LEN_PAGE);

    always_comb begin
        mode = '0;
        if (single_forced) begin
            mode.full = 1'b0;
            mode.ilv  = 1'b0;
            mode.mask = '0;
        end else if (page_sel) begin
            mode.full = 1'b1;
            mode.ilv  = 1'b0;
            mode.mask = '1;
        end else begin
            mode.full = 1'b0;
            mode.ilv  = burst_type;
            mode.mask = fixed_mask(len_code);
        end
    end

endmodule

// File: rtl/bcg_beat_ctrl.sv
module bcg_beat_ctrl
    import bcg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  burst_mode_t      new_mode,
    input  logic             stop,
    output burst_state_t     state,
    output logic             at_end
);

    burst_state_t cur;

    assign at_end = cur.active && !cur.mode.full && (cur.beat == cur.mode.mask);
    assign state  = cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (start) begin
            cur.active <= 1'b1;
            cur.base   <= start_col;
            cur.beat   <= '0;
            cur.mode   <= new_mode;
        end else if (cur.active) begin
            if (stop || at_end) begin
                cur.active <= 1'b0;
                cur.beat   <= '0;
            end else begin
                cur.beat <= cur.beat + PAGE_W'(1);
            end
        end
    end

endmodule

// File: rtl/bcg_addr_form.sv
module bcg_addr_form
    import bcg_pkg::*;
(
    input  burst_state_t     state,
    output logic [COL_W-1:0] addr
);

    logic [PAGE_W-1:0] seq_low;
    logic [PAGE_W-1:0] ilv_low;

    assign seq_low = state.base[PAGE_W-1:0] + state.beat;
    assign ilv_low = state.base[PAGE_W-1:0] ^ state.beat;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        if (b < PAGE_W) begin : g_low
            always_comb begin
                if (!state.mode.mask[b])
                    addr[b] = state.base[b];
                else if (state.mode.ilv)
                    addr[b] = ilv_low[b];
                else
                    addr[b] = seq_low[b];
            end
        end else begin : g_high
            assign addr[b] = state.base[b];
        end
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic [CODE_W-1:0] len_code,
    input  logic              burst_type,
    input  logic              wr_single,
    input  logic              is_write,
    input  logic              stop,
    output logic [COL_W-1:0]  col,
    output logic              valid,
    output logic              last
);

    burst_mode_t      dec_mode;
    burst_state_t     st;
    logic             end_beat;
    logic [COL_W-1:0] formed;

    bcg_mode_decode u_dec (
        .len_code   (len_code),
        .burst_type (burst_type),
        .wr_single  (wr_single),
        .is_write   (is_write),
        .mode       (dec_mode)
    );

    bcg_beat_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_col (start_col),
        .new_mode  (dec_mode),
        .stop      (stop),
        .state     (st),
        .at_end    (end_beat)
    );

    bcg_addr_form u_form (
        .state (st),
        .addr  (formed)
    );

    assign valid = st.active;
    assign last  = end_beat;
    assign col   = st.active ? formed : '0;

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker
    import bcg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [COL_W-1:0]  start_col,
    input logic [CODE_W-1:0] len_code,
    input logic              burst_type,
    input logic              wr_single,
    input logic              is_write,
    input logic              stop,
    input logic [COL_W-1:0]  col,
    input logic              valid,
    input logic              last
);

    logic resv_code;
    assign resv_code = (len_code == 3'b100) || (len_code == 3'b101) || (len_code == 3'b110);

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) !valid |-> (col == '0)); // R1
    AST_LAST_IN_VALID: assert property (@(posedge clk) disable iff (rst) last |-> valid); // R11
    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (rst) start |=> (valid && col == $past(start_col))); // R2
    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst) (stop && valid && !start) |=> !valid); // R9
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst) (last && !start) |=> !valid); // R5
    AST_RUN_ON: assert property (@(posedge clk) disable iff (rst) (valid && !last && !stop && !start) |=> valid); // R5
    AST_RESV_ONE: assert property (@(posedge clk) disable iff (rst) (start && resv_code) |=> last); // R6
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst) (start && is_write && wr_single) |=> last); // R8
    AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (rst) (start && len_code == 3'b111 && !(is_write && wr_single)) |=> !last); // R7
    AST_NO_GAP: assert property (@(posedge clk) disable iff (rst) (start && valid) |=> valid); // R10

endmodule

bind burst_col_gen bcg_checker u_chk (.*);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;
    import bcg_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              start;
    logic [COL_W-1:0]  start_col;
    logic [CODE_W-1:0] len_code;
    logic              burst_type;
    logic              wr_single;
    logic              is_write;
    logic              stop;
    logic [COL_W-1:0]  col;
    logic              valid;
    logic              last;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    burst_col_gen uut (.*);

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish (actual cycles=%0d expected <150000)", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic int exp_len(input logic [2:0] code, input logic ws, input logic wr);
        if (wr && ws) return 1;
        case (code)
            3'b000: return 1;
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            3'b111: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic logic [8:0] exp_col(input logic [8:0] s, input int len, input logic bt, input int i);
        logic [8:0] m;
        logic [8:0] lo;
        if (len == 0) begin
            return {s[8], 8'(s[7:0] + 8'(i))};
        end
        m = 9'(len - 1);
        if (bt) lo = s ^ 9'(i);
        else    lo = s + 9'(i);
        return (s & ~m) | (lo & m);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_burst(input logic [8:0] s, input logic [2:0] code, input logic bt,
                             input logic ws, input logic wr, input int stop_at, input string req);
        int len;
        len = exp_len(code, ws, wr);
        start = 1'b1; start_col = s; len_code = code; burst_type = bt;
        wr_single = ws; is_write = wr;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 100000; i++) begin
            logic exp_last;
            exp_last = (len != 0) && (i == len - 1);
            chk(valid === 1'b1, req, int'(valid), 1);
            chk(col === exp_col(s, len, bt, i), req, int'(col), int'(exp_col(s, len, bt, i)));
            chk(last === exp_last, req, int'(last), int'(exp_last));
            if (i == stop_at) begin
                stop = 1'b1;
                @(negedge clk);
                stop = 1'b0;
                chk(valid === 1'b0 && col === 9'd0, "R9", int'(valid), 0);
                break;
            end
            if (exp_last) begin
                @(negedge clk);
                chk(valid === 1'b0 && last === 1'b0, "R5", int'(valid), 0);
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        int seed;
        rst = 1'b1; start = 1'b0; start_col = '0; len_code = '0; burst_type = 1'b0;
        wr_single = 1'b0; is_write = 1'b0; stop = 1'b0;
        seed = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(valid === 1'b0 && last === 1'b0 && col === 9'd0, "R1", int'(col), 0);

        run_burst(9'h0a5, 3'b011, 1'b0, 1'b0, 1'b0, 999, "R3");
        run_burst(9'h0a5, 3'b011, 1'b1, 1'b0, 1'b0, 999, "R4");
        run_burst(9'h1fe, 3'b010, 1'b1, 1'b0, 1'b0, 999, "R4");
        run_burst(9'h133, 3'b001, 1'b0, 1'b0, 1'b0, 999, "R5");
        run_burst(9'h077, 3'b000, 1'b0, 1'b0, 1'b0, 999, "R5");
        run_burst(9'h03c, 3'b100, 1'b0, 1'b0, 1'b0, 999, "R6");
        run_burst(9'h03c, 3'b101, 1'b1, 1'b0, 1'b0, 999, "R6");
        run_burst(9'h03c, 3'b110, 1'b0, 1'b0, 1'b1, 999, "R6");
        run_burst(9'h1f0, 3'b111, 1'b1, 1'b0, 1'b0, 300, "R7");
        run_burst(9'h0c6, 3'b011, 1'b0, 1'b1, 1'b1, 999, "R8");
        run_burst(9'h0c6, 3'b011, 1'b0, 1'b1, 1'b0, 999, "R8");
        run_burst(9'h0c6, 3'b111, 1'b0, 1'b1, 1'b1, 999, "R8");
        run_burst(9'h155, 3'b011, 1'b1, 1'b0, 1'b0, 2, "R9");

        // R9: stop while idle leaves the next burst untouched
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk(valid === 1'b0, "R9", int'(valid), 0);
        run_burst(9'h012, 3'b010, 1'b0, 1'b0, 1'b0, 999, "R9");

        // R10: restart on the last beat, then mid-burst
        start = 1'b1; start_col = 9'h020; len_code = 3'b001; burst_type = 1'b0;
        wr_single = 1'b0; is_write = 1'b0;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(last === 1'b1, "R10", int'(last), 1);
        start = 1'b1; start_col = 9'h1c3; len_code = 3'b011; burst_type = 1'b1;
        @(negedge clk);
        chk(valid === 1'b1 && col === 9'h1c3, "R10", int'(col), 'h1c3);
        start_col = 9'h044; len_code = 3'b010; burst_type = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(valid === 1'b1 && col === 9'h044, "R10", int'(col), 'h44);
        @(negedge clk);
        chk(col === 9'h045, "R10", int'(col), 'h45);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk(valid === 1'b0, "R9", int'(valid), 0);

        for (int n = 0; n < 60; n++) begin
            logic [2:0] c;
            int sa;
            c = 3'($urandom);
            sa = (c == 3'b111) ? int'($urandom_range(1, 280)) :
                 (($urandom % 3) == 0) ? int'($urandom_range(0, 7)) : 999;
            run_burst(9'($urandom), c, 1'($urandom), 1'($urandom), 1'($urandom), sa, "R3");
            if (($urandom % 2) == 0) @(negedge clk);
        end

        // R11: idle outputs hold after all traffic
        @(negedge clk);
        chk(last === 1'b0 && valid === 1'b0, "R11", int'(last), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule